// File: doc/BRIEF.md
# Serial Bus Condition Detector

This block watches a two-wire synchronous serial bus: a clock line and a bidirectional data line. The sampled line levels are resynchronized into the system clock domain. The block then looks for edges of the data line that happen while the clock line stays high. A rising data edge in that window means the bus is released. A falling data edge in that window means a command follows. Both are held as sticky status flags, and together they tell the receiver how to treat the next byte. A byte that comes after a release and then a command is an address. A byte that comes after a command with no release before it is a command.

The receiver that shifts the data bits in reports each completed byte with a one-cycle strobe. After that strobe the block watches the next clock period on the bus. If the data line is held low for the whole high phase of that period, it records an acknowledge. Each flag stays set until software clears it with a one-cycle pulse. This block does not shift data and does not drive the line.

Top module: `bus_cond_detect`

## Requirements
- R1: A rising data-line edge while the clock line stays high on both sides of the edge sets `rel_flag`.
- R2: A falling data-line edge while the clock line stays high on both sides of the edge sets `cmd_flag`.
- R3: A release condition clears `cmd_flag` in the same cycle that it sets `rel_flag`.
- R4: On a command condition, `is_addr` becomes 1 if `rel_flag` is 1 at that moment (the next byte is an address).
- R5: On a command condition, `is_addr` becomes 0 if `rel_flag` is 0 at that moment (the next byte is a command). Outside command conditions, `is_addr` holds its value.
- R6: After a `byte_done` pulse, `ack_flag` is set when the data line is low at the next clock-line rise and stays low until the following clock-line fall.
- R7: `ack_flag` stays clear in three cases: the data line is high at that clock rise, the data line goes high before the clock falls, or no `byte_done` came first.
- R8: A data-line change is ignored in two cases: the clock line changes in the same synchronized sample, or the clock line is low.
- R9: Each flag holds until its clear input pulses. A clear wins over a set in the same cycle.
- R10: After reset, all four outputs are 0. A pin change shows on the flags at the third rising clock edge after it is presented, which allows two synchronizer stages plus one flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_pin | input | 1 | Bus clock line level, asynchronous |
| sda_pin | input | 1 | Bus data line level, asynchronous |
| byte_done | input | 1 | One-cycle strobe: receiver finished a byte |
| clr_rel | input | 1 | One-cycle clear of `rel_flag` |
| clr_cmd | input | 1 | One-cycle clear of `cmd_flag` |
| clr_ack | input | 1 | One-cycle clear of `ack_flag` |
| rel_flag | output | 1 | Release condition seen |
| cmd_flag | output | 1 | Command condition seen |
| ack_flag | output | 1 | Acknowledge seen |
| is_addr | output | 1 | 1: next byte is an address; 0: next byte is a command |

## Verification
Two events can land on the same flag in the same cycle: a software clear and a bus condition that sets the flag. The bench times the clear so that it meets the release event at the flag register. It then checks that the flag reads 0, and also that the release still cleared the command flag. A second collision is a release that happens while the acknowledge window is open. This is provoked by raising the data line during the high phase after a byte. The bench expects the release flag to be set and the acknowledge flag to stay clear.

// File: rtl/bcd_pkg.sv
// Package: shared types and flag indices for the bus condition detector.
package bcd_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_ARMED = 2'd1,
        ACK_HIGH  = 2'd2
    } ack_st_t;

    localparam int NUM_FLAGS = 3;
    localparam int F_REL = 0;
    localparam int F_CMD = 1;
    localparam int F_ACK = 2;
endpackage

// File: rtl/bcd_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is independent. Resets to RST_VAL, which should be the idle bus level.
module bcd_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each stage by one register per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[g] <= {WIDTH{RST_VAL}};
                else if (g == 0)
                    stage[g] <= d_async;
                else
                    stage[g] <= stage[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/bcd_cond.sv
// Module: bus event decoder.
// Compares consecutive synchronized samples. It reports clock-line edges, plus data-line
// edges that occur while the clock line is high in both samples. Assumes the inputs are
// already synchronized.
module bcd_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic rel_ev,
    output logic cmd_ev
);
    logic scl_q;
    logic sda_q;
    logic scl_held_high;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges. A data edge counts only when the clock is high in both samples.
    always_comb begin
        scl_held_high = scl_q & scl_s;
        scl_rise      = ~scl_q & scl_s;
        scl_fall      = scl_q & ~scl_s;
        rel_ev        = scl_held_high & ~sda_q & sda_s;
        cmd_ev        = scl_held_high & sda_q & ~sda_s;
    end
endmodule

// File: rtl/bcd_ack.sv
// Module: acknowledge window tracker.
// Armed by the byte-done strobe. It then requires the data line to be low at the next
// clock rise and to stay low until the clock falls. Emits a one-cycle set pulse.
module bcd_ack
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_s,
    output logic ack_set
);
    ack_st_t st_q;
    ack_st_t st_d;

    // Next-state and set-pulse logic.
    always_comb begin
        st_d    = st_q;
        ack_set = 1'b0;
        case (st_q)
            ACK_ARMED: begin
                if (scl_rise)
                    st_d = sda_s ? ACK_IDLE : ACK_HIGH;
            end
            ACK_HIGH: begin
                if (sda_s)
                    st_d = ACK_IDLE;
                else if (scl_fall) begin
                    ack_set = 1'b1;
                    st_d    = ACK_IDLE;
                end
            end
            default: st_d = ACK_IDLE;
        endcase
        if (byte_done)
            st_d = ACK_ARMED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ACK_IDLE;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/bcd_flag.sv
// Module: sticky status bit.
// Priority, highest first: software clear, then set, then drop. Drop is an automatic
// clear raised by another bus event.
module bcd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic drop,
    input  logic clr,
    output logic q
);
    // Update the flag with clear-first priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (drop)
            q <= 1'b0;
    end
endmodule

// File: rtl/bus_cond_detect.sv
// Module: serial bus condition detector, top level.
// Synchronizes both bus lines and decodes release and command conditions. Tracks the
// acknowledge window, keeps three sticky flags and an address/command qualifier for the
// next byte. Assumes byte_done and the clear inputs are already in the clk domain.
module bus_cond_detect
    import bcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    input  logic byte_done,
    input  logic clr_rel,
    input  logic clr_cmd,
    input  logic clr_ack,
    output logic rel_flag,
    output logic cmd_flag,
    output logic ack_flag,
    output logic is_addr
);
    logic [1:0] lines_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       rel_ev;
    logic       cmd_ev;
    logic       ack_set;

    logic [NUM_FLAGS-1:0] f_set;
    logic [NUM_FLAGS-1:0] f_drop;
    logic [NUM_FLAGS-1:0] f_clr;
    logic [NUM_FLAGS-1:0] f_q;
    logic                 addr_q;

    bcd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_pin, sda_pin}),
        .q_sync  (lines_s)
    );

    bcd_cond i_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .rel_ev   (rel_ev),
        .cmd_ev   (cmd_ev)
    );

    bcd_ack i_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (lines_s[0]),
        .ack_set   (ack_set)
    );

    // Map events and clears onto the flag vector.
    always_comb begin
        f_set         = '0;
        f_drop        = '0;
        f_clr         = '0;
        f_set[F_REL]  = rel_ev;
        f_set[F_CMD]  = cmd_ev;
        f_set[F_ACK]  = ack_set;
        f_drop[F_CMD] = rel_ev;
        f_clr[F_REL]  = clr_rel;
        f_clr[F_CMD]  = clr_cmd;
        f_clr[F_ACK]  = clr_ack;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_FLAGS; i++) begin : g_flag
            bcd_flag i_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (f_set[i]),
                .drop  (f_drop[i]),
                .clr   (f_clr[i]),
                .q     (f_q[i])
            );
        end
    endgenerate

    // Latch the byte class when a command condition arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= 1'b0;
        else if (cmd_ev)
            addr_q <= f_q[F_REL];
    end

    assign rel_flag = f_q[F_REL];
    assign cmd_flag = f_q[F_CMD];
    assign ack_flag = f_q[F_ACK];
    assign is_addr  = addr_q;
endmodule

// File: rtl/bcd_checker.sv
// Module: property checker for bus_cond_detect, attached with bind. Observes ports only.
module bcd_checker (
    input logic clk,
    input logic rst_n,
    input logic clr_rel,
    input logic clr_cmd,
    input logic clr_ack,
    input logic rel_flag,
    input logic cmd_flag,
    input logic ack_flag,
    input logic is_addr
);
    assert_clr_rel_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rel |=> !rel_flag);
    assert_clr_cmd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> !cmd_flag);
    assert_clr_ack_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ack |=> !ack_flag);
    assert_rel_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_flag && !clr_rel) |=> rel_flag);
    assert_ack_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_flag && !clr_ack) |=> ack_flag);
    assert_rel_drops_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_flag) |-> !cmd_flag);
    assert_addr_after_rel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_addr) |-> $past(rel_flag));
    assert_cmd_without_rel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_addr) |-> !$past(rel_flag));
endmodule

bind bus_cond_detect bcd_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_rel  (clr_rel),
    .clr_cmd  (clr_cmd),
    .clr_ack  (clr_ack),
    .rel_flag (rel_flag),
    .cmd_flag (cmd_flag),
    .ack_flag (ack_flag),
    .is_addr  (is_addr)
);

// File: tb/test_bus_cond_detect.sv
// Bench: a vector walk for the main flows, then directed tests for clear priority and reset.
module test_bus_cond_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_pin = 1'b1;
    logic sda_pin = 1'b1;
    logic byte_done = 1'b0;
    logic clr_rel = 1'b0;
    logic clr_cmd = 1'b0;
    logic clr_ack = 1'b0;
    logic rel_flag;
    logic cmd_flag;
    logic ack_flag;
    logic is_addr;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    bus_cond_detect i_bus_cond_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pin   (scl_pin),
        .sda_pin   (sda_pin),
        .byte_done (byte_done),
        .clr_rel   (clr_rel),
        .clr_cmd   (clr_cmd),
        .clr_ack   (clr_ack),
        .rel_flag  (rel_flag),
        .cmd_flag  (cmd_flag),
        .ack_flag  (ack_flag),
        .is_addr   (is_addr)
    );

    // Vector bits, MSB first: scl, sda, byte_done, clr_ack, clr_cmd, clr_rel,
    // then the expected rel, cmd, ack, addr.
    localparam logic [9:0] VEC [0:20] = '{
        10'b110000_0000, // R10 idle
        10'b100000_0100, // R2 R5 command, no release
        10'b110000_1000, // R1 R3 release clears command
        10'b100000_1101, // R4 command after release
        10'b000000_1101, // R9 clock falls, flags hold
        10'b010000_1101, // R8 data rises, clock low
        10'b000000_1101, // R8 data falls, clock low
        10'b000011_0001, // R9 clear rel and cmd
        10'b110000_0001, // R8 coincident clock and data rise
        10'b100000_0100, // R5 command, no release
        10'b001000_0100, // R6 byte done, clock low
        10'b100000_0100, // R6 clock rises, data low
        10'b000000_0110, // R6 clock falls, acknowledge
        10'b000100_0100, // R9 clear ack
        10'b011000_0100, // R7 byte done, data high
        10'b110000_0100, // R7 clock rises, data high
        10'b010000_0100, // R7 no acknowledge
        10'b001000_0100, // R7 byte done, data low
        10'b100000_0100, // R7 clock rises, data low
        10'b110000_1000, // R7 R1 release aborts window
        10'b010000_1000  // R7 no acknowledge after abort
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rel,cmd,ack,addr actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R10 reset", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int k = 0; k < 21; k++) begin
            {scl_pin, sda_pin, byte_done, clr_ack, clr_cmd, clr_rel} = VEC[k][9:4];
            @(negedge clk);
            {byte_done, clr_ack, clr_cmd, clr_rel} = 4'b0000;
            repeat (3) @(negedge clk);
            check($sformatf("vector %0d", k), {rel_flag, cmd_flag, ack_flag, is_addr}, VEC[k][3:0]);
        end

        // R9 / R3: a clear of rel meets a release event at the flag register.
        scl_pin = 1'b1;
        repeat (4) @(negedge clk);
        sda_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 setup", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b1101);
        sda_pin = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        clr_rel = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_rel = 1'b0;
        check("R9 clear beats release", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0001);
        repeat (3) @(negedge clk);
        check("R3 R9 stays clear", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0001);

        // R2 / R10: a command shows at the third edge, not earlier.
        sda_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 latency early", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0001);
        @(negedge clk);
        check("R2 R10 latency", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0100);

        // R10: reset in mid-run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 mid reset", {rel_flag, cmd_flag, ack_flag, is_addr}, 4'b0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule